// File: doc/BRIEF.md
# Serial Transmit Channel with Command Register

This block is the transmit side of an asynchronous serial channel, steered by a write-only command word. Each command write carries two fields: a three-bit housekeeping code (pointer reset, receiver reset, transmitter reset, error clear, break-change clear, break on, break off) and a two-bit transmitter control code (keep, enable, disable, reserved). Characters enter a one-deep holding register and move into a shift register that frames them with one low start bit, eight data bits sent least significant bit first, and one high stop bit. Each bit lasts one period of the external bit-rate tick.

Disabling the transmitter takes effect on the status flags at once, but a character already being shifted out still finishes. A break holds the line low. It waits for any character in the shift register to finish, starts on a bit tick, and keeps any held character back until the break is lifted. The block also keeps the receive-side status that the command word can clear: a small receive fill count with its ready and full flags, four sticky error flags, a break-change flag and a mode-register pointer. The events that set these come in on plain pulse inputs from the receiver and register logic.

Top module: `serial_tx_cmd`

## Requirements
- R1: After reset, txd is high (mark), the transmitter is disabled (txReady=0, txEmpty=0), rxOn=0, rxReady=0, fifoFull=0, errFlags=0, deltaBrk=0 and modePtr=0.
- R2: A command write with control code 01 enables the transmitter. With the holding and shift registers empty and no break, txReady and txEmpty both read 1 on the cycle after the write. Enabling again changes nothing.
- R3: Control code 10 disables the transmitter: txReady and txEmpty read 0 on the cycle after the write. A frame already started completes all ten bits, and a character left in the holding register is not sent until the transmitter is enabled again. Codes 00 and 11 leave the enabled state unchanged.
- R4: A frame is a low start bit, the eight data bits LSB first, then a high stop bit, each one bit-tick period long, starting on a bit tick. A data write is taken only while txReady=1; otherwise it is ignored. A frame starts only while ctsN=0.
- R5: Housekeeping code 011 (reset transmitter) disables the transmitter, drops any held or shifting character and any break, and returns txd high on the next cycle. The receive-side status is not altered.
- R6: Code 110 (break on) is accepted only while the transmitter is enabled, and it ignores ctsN. It waits until any frame in the shift register has finished, then drives txd low from a bit tick. While the break lasts, a held character is not sent.
- R7: Code 111 (break off) returns txd high at the next bit tick. A held character then starts one bit tick later, after at least one full mark bit.
- R8: txEmpty reads 0 while a break is pending or active.
- R9: Code 010 (reset receiver) clears rxOn and empties the receive fill count, so rxReady=0 and fifoFull=0. Receive pushes are ignored until rxEnIn pulses.
- R10: Code 100 clears errFlags (bit 0 overrun, bit 1 parity, bit 2 framing, bit 3 received break) and leaves deltaBrk alone. Code 101 clears deltaBrk and leaves errFlags alone. Error bits set through rxErrIn are sticky.
- R11: Code 001 returns modePtr to 0. modeAdvIn sets it to 1.
- R12: When one write carries both fields, the housekeeping code acts first and the control code second. So 011 with 01 leaves an enabled, empty transmitter, and 110 with 01 on a disabled transmitter starts no break.
- R13: rxReady is 1 while the fill count is above zero, and fifoFull is 1 while it equals RX_DEPTH (default 3). Pushes at full are dropped, and rxPopIn lowers the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdWr | input | 1 | Command word write strobe |
| cmdMisc | input | 3 | Housekeeping command code |
| cmdTxCtl | input | 2 | Transmitter control code |
| dataWr | input | 1 | Write strobe for the holding register |
| dataIn | input | DATA_W | Character to send |
| bitTick | input | 1 | One-cycle pulse per bit period |
| ctsN | input | 1 | Clear-to-send, active low |
| rxEnIn | input | 1 | Pulse that turns the receiver on |
| rxCharIn | input | 1 | Pulse: receiver delivered a character |
| rxPopIn | input | 1 | Pulse: one received character consumed |
| rxErrIn | input | 4 | Error bits to set (overrun, parity, framing, break) |
| brkChgIn | input | 1 | Pulse: received break state changed |
| modeAdvIn | input | 1 | Pulse: mode pointer moves to the second mode register |
| txd | output | 1 | Serial transmit line |
| txReady | output | 1 | Holding register free on an enabled transmitter |
| txEmpty | output | 1 | Enabled with holding and shift registers empty and no break |
| rxOn | output | 1 | Receiver enabled |
| rxReady | output | 1 | At least one received character held |
| fifoFull | output | 1 | Receive fill count at RX_DEPTH |
| errFlags | output | 4 | Sticky receive error flags |
| deltaBrk | output | 1 | Break-change flag |
| modePtr | output | 1 | Mode register pointer |

## Verification
The assertions assume bitTick is a single-cycle pulse with at least two idle cycles between pulses. They also assume a command word carries a single housekeeping code per write, and that the receive pulses are one cycle wide. The stimulus makes the tick from a fixed four-cycle pattern. It drives every command, data and receive pulse for exactly one cycle from the falling clock edge, and it waits for txd to fall before it issues commands against a frame in flight. It never drives dataWr while the holding register is full, except to show that such a write is dropped.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [2:0] {
    MISC_NONE     = 3'b000,
    MISC_RST_PTR  = 3'b001,
    MISC_RST_RX   = 3'b010,
    MISC_RST_TX   = 3'b011,
    MISC_RST_ERR  = 3'b100,
    MISC_RST_DBRK = 3'b101,
    MISC_BRK_ON   = 3'b110,
    MISC_BRK_OFF  = 3'b111
  } miscCmd_e;

  typedef enum logic [1:0] {
    TXC_KEEP = 2'b00,
    TXC_ON   = 2'b01,
    TXC_OFF  = 2'b10,
    TXC_RSVD = 2'b11
  } txCtl_e;

  // control -> transmit datapath
  typedef struct packed {
    logic flushTx;    // drop held and shifting character now
    logic txAllowed;  // transmitter enabled
    logic lineHold;   // break pending, active or ending: no new frame
    logic lineLow;    // break driving the line low
  } txStrobe_t;

  // control -> receive status
  typedef struct packed {
    logic rstRx;
    logic rstErr;
    logic rstDelta;
    logic rstPtr;
  } rxStrobe_t;

endpackage

// File: rtl/sertx_ctl.sv
module sertx_ctl
  import sertx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmdWr,
  input  logic [2:0] cmdMisc,
  input  logic [1:0] cmdTxCtl,
  input  logic       bitTick,
  input  logic       shiftBusy,
  input  logic       holdValid,
  output txStrobe_t  txStb,
  output rxStrobe_t  rxStb,
  output logic       txReady,
  output logic       txEmpty
);

  miscCmd_e miscCode;
  txCtl_e   ctlCode;
  assign miscCode = miscCmd_e'(cmdMisc);
  assign ctlCode  = txCtl_e'(cmdTxCtl);

  logic isRstTx, isBrkOn, isBrkOff;
  assign isRstTx  = cmdWr && (miscCode == MISC_RST_TX);
  assign isBrkOn  = cmdWr && (miscCode == MISC_BRK_ON);
  assign isBrkOff = cmdWr && (miscCode == MISC_BRK_OFF);

  logic txOn, brkPend, brkAct, brkStop;
  logic txOnN, brkPendN, brkActN, brkStopN;

  // Housekeeping code is applied before the control code (same write).
  always_comb begin
    txOnN    = txOn;
    brkPendN = brkPend;
    brkActN  = brkAct;
    brkStopN = brkStop;
    if (bitTick) begin
      if (brkStop) begin
        brkActN  = 1'b0;
        brkStopN = 1'b0;
      end else if (brkPend && !shiftBusy) begin
        brkActN  = 1'b1;
        brkPendN = 1'b0;
      end
    end
    if (isRstTx) begin
      txOnN    = 1'b0;
      brkPendN = 1'b0;
      brkActN  = 1'b0;
      brkStopN = 1'b0;
    end
    if (isBrkOn && txOn) begin
      if (brkAct) brkStopN = 1'b0;
      else        brkPendN = 1'b1;
    end
    if (isBrkOff) begin
      brkPendN = 1'b0;
      if (brkAct) brkStopN = 1'b1;
    end
    if (cmdWr) begin
      case (ctlCode)
        TXC_ON:  txOnN = 1'b1;
        TXC_OFF: txOnN = 1'b0;
        default: txOnN = txOnN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txOn    <= 1'b0;
      brkPend <= 1'b0;
      brkAct  <= 1'b0;
      brkStop <= 1'b0;
    end else begin
      txOn    <= txOnN;
      brkPend <= brkPendN;
      brkAct  <= brkActN;
      brkStop <= brkStopN;
    end
  end

  assign txStb.flushTx   = isRstTx;
  assign txStb.txAllowed = txOn;
  assign txStb.lineHold  = brkPend | brkAct | brkStop;
  assign txStb.lineLow   = brkAct;

  assign rxStb.rstRx    = cmdWr && (miscCode == MISC_RST_RX);
  assign rxStb.rstErr   = cmdWr && (miscCode == MISC_RST_ERR);
  assign rxStb.rstDelta = cmdWr && (miscCode == MISC_RST_DBRK);
  assign rxStb.rstPtr   = cmdWr && (miscCode == MISC_RST_PTR);

  assign txReady = txOn && !holdValid;
  assign txEmpty = txReady && !shiftBusy && !txStb.lineHold;

  AST_BRK_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brkPend) |-> $past(txOn)); // R6
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cmdWr && (cmdTxCtl == 2'b10) |=> !txReady && !txEmpty); // R3
  AST_BRK_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brkAct) |=> !txEmpty); // R8

endmodule

// File: rtl/sertx_dp.sv
module sertx_dp
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bitTick,
  input  logic              ctsN,
  input  logic              dataWr,
  input  logic [DATA_W-1:0] dataIn,
  input  txStrobe_t         stb,
  output logic              txd,
  output logic              shiftBusy,
  output logic              holdValid
);

  localparam int FRAME_W = DATA_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [DATA_W-1:0]  holdQ;
  logic [FRAME_W-1:0] shiftQ;
  logic [CNT_W-1:0]   bitsLeft;
  logic               busyQ;

  logic frameSlot, canStart, loadNow;
  assign frameSlot = bitTick && (!busyQ || (bitsLeft == CNT_W'(1)));
  assign canStart  = stb.txAllowed && holdValid && !ctsN && !stb.lineHold;
  assign loadNow   = frameSlot && canStart;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      holdQ     <= '0;
      holdValid <= 1'b0;
      shiftQ    <= '1;
      bitsLeft  <= '0;
      busyQ     <= 1'b0;
    end else if (stb.flushTx) begin
      holdValid <= 1'b0;
      shiftQ    <= '1;
      bitsLeft  <= '0;
      busyQ     <= 1'b0;
    end else begin
      if (loadNow) begin
        shiftQ   <= {1'b1, holdQ, 1'b0};
        bitsLeft <= CNT_W'(FRAME_W);
        busyQ    <= 1'b1;
      end else if (frameSlot) begin
        bitsLeft <= '0;
        busyQ    <= 1'b0;
      end else if (bitTick && busyQ) begin
        shiftQ   <= {1'b1, shiftQ[FRAME_W-1:1]};
        bitsLeft <= bitsLeft - CNT_W'(1);
      end
      if (loadNow) begin
        holdValid <= 1'b0;
      end else if (dataWr && stb.txAllowed && !holdValid) begin
        holdValid <= 1'b1;
        holdQ     <= dataIn;
      end
    end
  end

  assign shiftBusy = busyQ;
  assign txd       = busyQ ? shiftQ[0] : ~stb.lineLow;

  AST_FLUSH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    stb.flushTx |=> !busyQ && !holdValid); // R5
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busyQ) |-> !txd); // R4
  AST_CTS_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busyQ) |-> !$past(ctsN)); // R4
  AST_NO_FRAME_IN_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busyQ) |-> !$past(stb.lineHold)); // R6
  AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    holdValid && !loadNow && !stb.flushTx |=> holdValid && $stable(holdQ)); // R4

endmodule

// File: rtl/sertx_rxstat.sv
module sertx_rxstat
  import sertx_pkg::*;
#(
  parameter int RX_DEPTH = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  rxStrobe_t  stb,
  input  logic       rxEnIn,
  input  logic       rxCharIn,
  input  logic       rxPopIn,
  input  logic [3:0] rxErrIn,
  input  logic       brkChgIn,
  input  logic       modeAdvIn,
  output logic       rxOn,
  output logic       rxReady,
  output logic       fifoFull,
  output logic [3:0] errFlags,
  output logic       deltaBrk,
  output logic       modePtr
);

  localparam int CNT_W = $clog2(RX_DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(RX_DEPTH);

  logic [CNT_W-1:0] fillCnt;
  logic pushOk, popOk;
  assign pushOk = rxOn && rxCharIn && (fillCnt != FULL_CNT);
  assign popOk  = rxPopIn && (fillCnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxOn     <= 1'b0;
      fillCnt  <= '0;
      errFlags <= '0;
      deltaBrk <= 1'b0;
      modePtr  <= 1'b0;
    end else begin
      if (stb.rstRx) begin
        rxOn    <= 1'b0;
        fillCnt <= '0;
      end else begin
        if (rxEnIn) rxOn <= 1'b1;
        if (pushOk && !popOk)      fillCnt <= fillCnt + CNT_W'(1);
        else if (popOk && !pushOk) fillCnt <= fillCnt - CNT_W'(1);
      end
      if (stb.rstErr) errFlags <= '0;
      else            errFlags <= errFlags | rxErrIn;
      if (stb.rstDelta)   deltaBrk <= 1'b0;
      else if (brkChgIn)  deltaBrk <= 1'b1;
      if (stb.rstPtr)     modePtr <= 1'b0;
      else if (modeAdvIn) modePtr <= 1'b1;
    end
  end

  assign rxReady  = (fillCnt != '0);
  assign fifoFull = (fillCnt == FULL_CNT);

  AST_RXRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stb.rstRx |=> !rxReady && !fifoFull && !rxOn); // R9
  AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    stb.rstErr |=> errFlags == 4'b0000); // R10
  AST_PTR_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    stb.rstPtr |=> !modePtr); // R11
  AST_FULL_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    fifoFull |-> rxReady); // R13
  AST_NO_OVERFILL: assert property (@(posedge clk) disable iff (!rst_n)
    fifoFull && !popOk && !stb.rstRx |=> fifoFull); // R13

endmodule

// File: rtl/serial_tx_cmd.sv
module serial_tx_cmd
  import sertx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int RX_DEPTH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmdWr,
  input  logic [2:0]        cmdMisc,
  input  logic [1:0]        cmdTxCtl,
  input  logic              dataWr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              bitTick,
  input  logic              ctsN,
  input  logic              rxEnIn,
  input  logic              rxCharIn,
  input  logic              rxPopIn,
  input  logic [3:0]        rxErrIn,
  input  logic              brkChgIn,
  input  logic              modeAdvIn,
  output logic              txd,
  output logic              txReady,
  output logic              txEmpty,
  output logic              rxOn,
  output logic              rxReady,
  output logic              fifoFull,
  output logic [3:0]        errFlags,
  output logic              deltaBrk,
  output logic              modePtr
);

  txStrobe_t txStb;
  rxStrobe_t rxStb;
  logic      shiftBusy, holdValid;

  sertx_ctl ctl_i (
    .clk(clk), .rst_n(rst_n),
    .cmdWr(cmdWr), .cmdMisc(cmdMisc), .cmdTxCtl(cmdTxCtl),
    .bitTick(bitTick), .shiftBusy(shiftBusy), .holdValid(holdValid),
    .txStb(txStb), .rxStb(rxStb),
    .txReady(txReady), .txEmpty(txEmpty)
  );

  sertx_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rst_n(rst_n),
    .bitTick(bitTick), .ctsN(ctsN),
    .dataWr(dataWr), .dataIn(dataIn),
    .stb(txStb),
    .txd(txd), .shiftBusy(shiftBusy), .holdValid(holdValid)
  );

  sertx_rxstat #(.RX_DEPTH(RX_DEPTH)) rx_i (
    .clk(clk), .rst_n(rst_n), .stb(rxStb),
    .rxEnIn(rxEnIn), .rxCharIn(rxCharIn), .rxPopIn(rxPopIn),
    .rxErrIn(rxErrIn), .brkChgIn(brkChgIn), .modeAdvIn(modeAdvIn),
    .rxOn(rxOn), .rxReady(rxReady), .fifoFull(fifoFull),
    .errFlags(errFlags), .deltaBrk(deltaBrk), .modePtr(modePtr)
  );

endmodule

// File: tb/serial_tx_cmd_tb_top.sv
`timescale 1ns/100ps
module serial_tx_cmd_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmdWr = 1'b0;
  logic [2:0] cmdMisc = 3'b000;
  logic [1:0] cmdTxCtl = 2'b00;
  logic dataWr = 1'b0;
  logic [7:0] dataIn = 8'h00;
  logic bitTick = 1'b0;
  logic ctsN = 1'b1;
  logic rxEnIn = 1'b0, rxCharIn = 1'b0, rxPopIn = 1'b0;
  logic [3:0] rxErrIn = 4'b0000;
  logic brkChgIn = 1'b0, modeAdvIn = 1'b0;
  logic txd, txReady, txEmpty, rxOn, rxReady, fifoFull, deltaBrk, modePtr;
  logic [3:0] errFlags;

  int nTests = 0;
  int nFail = 0;
  bit done = 1'b0;

  serial_tx_cmd dut_i (
    .clk(clk), .rst_n(rst_n), .cmdWr(cmdWr), .cmdMisc(cmdMisc), .cmdTxCtl(cmdTxCtl),
    .dataWr(dataWr), .dataIn(dataIn), .bitTick(bitTick), .ctsN(ctsN),
    .rxEnIn(rxEnIn), .rxCharIn(rxCharIn), .rxPopIn(rxPopIn), .rxErrIn(rxErrIn),
    .brkChgIn(brkChgIn), .modeAdvIn(modeAdvIn),
    .txd(txd), .txReady(txReady), .txEmpty(txEmpty), .rxOn(rxOn), .rxReady(rxReady),
    .fifoFull(fifoFull), .errFlags(errFlags), .deltaBrk(deltaBrk), .modePtr(modePtr)
  );

  initial forever #2.5 clk = ~clk;

  // bit tick: one cycle high every four cycles
  initial begin
    forever begin
      repeat (3) @(negedge clk);
      bitTick = 1'b1;
      @(negedge clk);
      bitTick = 1'b0;
    end
  end

  task automatic checkEq(input string tag, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // all drive tasks are entered at a falling edge and leave one edge later
  task automatic cmd(input logic [2:0] m, input logic [1:0] c);
    cmdWr = 1'b1; cmdMisc = m; cmdTxCtl = c;
    @(negedge clk);
    cmdWr = 1'b0; cmdMisc = 3'b000; cmdTxCtl = 2'b00;
  endtask

  task automatic putData(input logic [7:0] d);
    dataWr = 1'b1; dataIn = d;
    @(negedge clk);
    dataWr = 1'b0;
  endtask

  task automatic waitLow(output bit seen, output int waited);
    seen = 1'b0;
    waited = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (txd == 1'b0) begin
        seen = 1'b1;
        return;
      end
      waited++;
    end
  endtask

  task automatic waitHigh(input int limit, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (txd == 1'b1) begin
        seen = 1'b1;
        return;
      end
    end
  endtask

  // called at the centre of the start bit
  task automatic sampleRest(output logic [9:0] bits);
    bits[0] = txd;
    for (int i = 1; i < 10; i++) begin
      repeat (4) @(negedge clk);
      bits[i] = txd;
    end
  endtask

  task automatic captureFrame(input string tag, output logic [9:0] bits);
    bit seen;
    int w;
    waitLow(seen, w);
    checkEq({tag, " frame start seen"}, int'(seen), 1);
    repeat (2) @(negedge clk);
    sampleRest(bits);
  endtask

  task automatic countLows(input int n, output int lows);
    lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (txd == 1'b0) lows++;
    end
  endtask

  function automatic logic [9:0] frameOf(input logic [7:0] d);
    return {1'b1, d, 1'b0};
  endfunction

  task automatic test_reset();
    checkEq("R1 txd idle high", int'(txd), 1);
    checkEq("R1 txReady", int'(txReady), 0);
    checkEq("R1 txEmpty", int'(txEmpty), 0);
    checkEq("R1 rx flags", int'({rxOn, rxReady, fifoFull, deltaBrk, modePtr}), 0);
    checkEq("R1 errFlags", int'(errFlags), 0);
  endtask

  task automatic test_enable();
    cmd(3'b000, 2'b01);
    checkEq("R2 enable txReady", int'(txReady), 1);
    checkEq("R2 enable txEmpty", int'(txEmpty), 1);
    cmd(3'b000, 2'b01);
    checkEq("R2 second enable no effect", int'({txReady, txEmpty}), 3);
    cmd(3'b000, 2'b11);
    checkEq("R3 reserved code keeps state", int'({txReady, txEmpty}), 3);
    cmd(3'b000, 2'b00);
    checkEq("R3 keep code keeps state", int'({txReady, txEmpty}), 3);
  endtask

  task automatic test_frames();
    logic [9:0] b;
    int lows;
    ctsN = 1'b1;
    putData(8'hA5);
    checkEq("R4 txReady low after write", int'(txReady), 0);
    putData(8'h11);
    countLows(30, lows);
    checkEq("R4 no frame while ctsN high", lows, 0);
    ctsN = 1'b0;
    captureFrame("R4", b);
    checkEq("R4 frame A5 (write while full dropped)", int'(b), int'(frameOf(8'hA5)));
    repeat (6) @(negedge clk);
    checkEq("R4 empty after frame", int'(txEmpty), 1);
    putData(8'h3C);
    captureFrame("R4", b);
    checkEq("R4 frame 3C", int'(b), int'(frameOf(8'h3C)));
    repeat (8) @(negedge clk);
  endtask

  task automatic test_disable();
    logic [9:0] b;
    bit seen;
    int w, lows;
    putData(8'h96);
    waitLow(seen, w);
    putData(8'h5A);
    cmd(3'b000, 2'b10);
    checkEq("R3 disable clears flags", int'({txReady, txEmpty}), 0);
    sampleRest(b);
    checkEq("R3 frame in flight completes", int'(b), int'(frameOf(8'h96)));
    countLows(48, lows);
    checkEq("R3 held char not sent while disabled", lows, 0);
    cmd(3'b000, 2'b01);
    checkEq("R4 holding still occupied after enable", int'(txReady), 0);
    captureFrame("R3", b);
    checkEq("R3 held char sent after enable", int'(b), int'(frameOf(8'h5A)));
    repeat (8) @(negedge clk);
  endtask

  task automatic test_break();
    logic [9:0] b;
    bit seen;
    int w, lows;
    ctsN = 1'b1;
    cmd(3'b110, 2'b00);
    checkEq("R8 txEmpty low with break pending", int'(txEmpty), 0);
    repeat (6) @(negedge clk);
    checkEq("R6 break low despite ctsN high", int'(txd), 0);
    putData(8'hC3);
    ctsN = 1'b0;
    countLows(40, lows);
    checkEq("R6 held char waits during break", lows, 40);
    checkEq("R8 txEmpty low during break", int'(txEmpty), 0);
    cmd(3'b111, 2'b00);
    waitHigh(8, seen);
    checkEq("R7 line high within two bit times", int'(seen), 1);
    waitLow(seen, w);
    checkEq("R7 mark before queued char", int'(w >= 3), 1);
    repeat (2) @(negedge clk);
    sampleRest(b);
    checkEq("R7 queued char after break", int'(b), int'(frameOf(8'hC3)));
    // break requested while a frame is shifting
    repeat (8) @(negedge clk);
    putData(8'h69);
    waitLow(seen, w);
    cmd(3'b110, 2'b00);
    @(negedge clk);
    sampleRest(b);
    checkEq("R6 break waits for shifting char", int'(b), int'(frameOf(8'h69)));
    repeat (10) @(negedge clk);
    checkEq("R6 break follows the char", int'(txd), 0);
    cmd(3'b111, 2'b00);
    repeat (10) @(negedge clk);
    checkEq("R7 break ended", int'(txd), 1);
    checkEq("R8 empty again after break", int'(txEmpty), 1);
    // break refused while disabled
    cmd(3'b000, 2'b10);
    cmd(3'b110, 2'b00);
    countLows(12, lows);
    checkEq("R6 break ignored when disabled", lows, 0);
    cmd(3'b110, 2'b01);
    countLows(12, lows);
    checkEq("R12 break then enable: no break", lows, 0);
    checkEq("R12 enabled and empty", int'(txEmpty), 1);
  endtask

  task automatic test_reset_tx();
    bit seen;
    int w, lows;
    rxErrIn = 4'b0101;
    @(negedge clk);
    rxErrIn = 4'b0000;
    putData(8'h00);
    waitLow(seen, w);
    cmd(3'b011, 2'b00);
    checkEq("R5 txd high after reset tx", int'(txd), 1);
    checkEq("R5 flags cleared", int'({txReady, txEmpty}), 0);
    checkEq("R5 errFlags untouched", int'(errFlags), 5);
    countLows(16, lows);
    checkEq("R5 no residual frame", lows, 0);
    cmd(3'b011, 2'b01);
    checkEq("R12 reset then enable", int'({txReady, txEmpty}), 3);
    cmd(3'b100, 2'b00);
  endtask

  task automatic test_rx();
    rxCharIn = 1'b1; @(negedge clk); rxCharIn = 1'b0;
    checkEq("R9 push ignored while receiver off", int'(rxReady), 0);
    rxEnIn = 1'b1; @(negedge clk); rxEnIn = 1'b0;
    rxCharIn = 1'b1; @(negedge clk); rxCharIn = 1'b0;
    checkEq("R13 one char ready not full", int'({rxReady, fifoFull}), 2);
    rxCharIn = 1'b1; repeat (3) @(negedge clk); rxCharIn = 1'b0;
    checkEq("R13 full at depth", int'({rxReady, fifoFull}), 3);
    rxPopIn = 1'b1; @(negedge clk); rxPopIn = 1'b0;
    checkEq("R13 pop from full (extra push dropped)", int'({rxReady, fifoFull}), 2);
    rxErrIn = 4'b1000; @(negedge clk); rxErrIn = 4'b0010; @(negedge clk); rxErrIn = 4'b0000;
    brkChgIn = 1'b1; @(negedge clk); brkChgIn = 1'b0;
    checkEq("R10 errors sticky", int'(errFlags), 10);
    cmd(3'b100, 2'b00);
    checkEq("R10 reset error", int'(errFlags), 0);
    checkEq("R10 deltaBrk kept", int'(deltaBrk), 1);
    rxErrIn = 4'b0001; @(negedge clk); rxErrIn = 4'b0000;
    cmd(3'b101, 2'b00);
    checkEq("R10 reset break change", int'(deltaBrk), 0);
    checkEq("R10 errFlags kept", int'(errFlags), 1);
    modeAdvIn = 1'b1; @(negedge clk); modeAdvIn = 1'b0;
    checkEq("R11 pointer advanced", int'(modePtr), 1);
    cmd(3'b001, 2'b00);
    checkEq("R11 pointer reset", int'(modePtr), 0);
    cmd(3'b010, 2'b00);
    checkEq("R9 receiver reset", int'({rxOn, rxReady, fifoFull}), 0);
    rxCharIn = 1'b1; @(negedge clk); rxCharIn = 1'b0;
    checkEq("R9 push ignored after reset", int'(rxReady), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_enable();
    test_frames();
    test_disable();
    test_break();
    test_reset_tx();
    test_rx();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule